// File: doc/BRIEF.md
# Per-Bit Programmable Two-Input Logic Unit

This block evaluates an arbitrary two-input boolean function across a 64-bit word, one bit position at a time. The function is not fixed in hardware. It comes at run time as a 4-entry truth table held in a third operand word. A one-bit select input chooses one of two nibbles of that word as the table. For every bit position, the pair (A bit, B bit) forms a 2-bit index, and the result bit is the table entry at that index. So one datapath can do AND, OR, XOR, NAND, pass-through, constant fill or any of the other sixteen functions. The choice can change on every request.

The evaluation is purely combinational. A small valid/ready wrapper captures the result into a register one cycle after a request is accepted. The wrapper holds the result until the consumer takes it. A new request can be accepted in the same cycle as the pending result is taken, so a stream runs at one result per cycle. The block changes no status or flag state.

Top module: `bitwise_lut_unit`

## Requirements
- R1: While and after reset, `outValid` is 0 and `inReady` is 1 until a request is accepted.
- R2: With `hiSel` = 0 the truth table is `opTable[3:0]` (MSB-0 bits 60..63).
- R3: With `hiSel` = 1 the truth table is `opTable[7:4]` (MSB-0 bits 56..59).
- R4: For each bit position k, `outData[k]` equals the table bit at LSB-0 index {`opA[k]`,`opB[k]`}, with `opA` as the high index bit. All 64 positions are independent. Bit 0 in MSB-0 numbering is `[63]`.
- R5: The result does not depend on `opTable` bits outside the selected nibble.
- R6: A request is accepted on a rising edge when `inValid` and `inReady` are both 1. At the next edge `outValid` is 1 and `outData` holds that request's result.
- R7: While `outValid` is 1 and `outReady` is 0, `inReady` is 0, and `outValid` and `outData` stay unchanged.
- R8: When `outValid` and `outReady` are both 1, `inReady` is 1, so back-to-back requests run at one per cycle. If no request is accepted in that cycle, `outValid` drops.
- R9: Table value 4'b1000 yields `opA & opB`. Table value 4'b0110 yields `opA ^ opB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| opA | input | 64 | First data operand (high index bit) |
| opB | input | 64 | Second data operand (low index bit) |
| opTable | input | 64 | Word holding the two candidate truth tables |
| hiSel | input | 1 | Selects table nibble: 0 = bits [3:0], 1 = bits [7:4] |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | 64 | Result word |

## Verification
Suppose the handshake state were wrong, for example a stuck or lost valid flag. The next accepted request would then show a missing or duplicated result, or a changed word during a stall, within one cycle. The scoreboard catches that as an out-of-order or extra comparison. Suppose instead the nibble choice or the index order were wrong. Then, within one cycle of acceptance, `outData` would show the wrong bits for the table patterns whose entries are not symmetric. The bench therefore uses random tables, toggles the unselected bits, and compares against plain AND and XOR.

// File: rtl/lut_unit_pkg.sv
package lut_unit_pkg;
  // number of function inputs and derived table size
  localparam int IN_CNT = 2;
  localparam int LUT_W  = 1 << IN_CNT;

  typedef struct packed {
    logic loadResult;   // capture combinational result into output register
  } ctrlStrobes_t;
endpackage

// File: rtl/lut_unit_ctrl.sv
module lut_unit_ctrl
  import lut_unit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic accept;
  logic validNext;

  // slot is free when empty or being drained this cycle
  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobes = '0;
    strobes.loadResult = accept;
  end

  always_comb begin
    validNext = outValid;
    if (accept)        validNext = 1'b1;
    else if (outReady) validNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= validNext;
  end
endmodule

// File: rtl/lut_unit_datapath.sv
module lut_unit_datapath
  import lut_unit_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opTable,
  input  logic              hiSel,
  output logic [DATA_W-1:0] outData
);
  localparam int NIB_CNT   = DATA_W / LUT_W;
  localparam int NIB_IDX_W = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1;

  logic [NIB_IDX_W-1:0] nibIdx;
  logic [LUT_W-1:0]     lutNib;
  logic [DATA_W-1:0]    evalWord;
  logic [DATA_W-1:0]    resultQ;

  // the flag picks nibble 0 or nibble 1 counted from the LSB end
  assign nibIdx = NIB_IDX_W'(hiSel);
  assign lutNib = opTable[nibIdx*LUT_W +: LUT_W];

  generate
    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      logic [IN_CNT-1:0] sel;
      assign sel         = {opA[k], opB[k]};
      assign evalWord[k] = lutNib[sel];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   resultQ <= '0;
    else if (strobes.loadResult) resultQ <= evalWord;
  end

  assign outData = resultQ;
endmodule

// File: rtl/bitwise_lut_unit.sv
module bitwise_lut_unit
  import lut_unit_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opTable,
  input  logic              hiSel,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);
  ctrlStrobes_t strobes;

  lut_unit_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  lut_unit_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .opTable (opTable),
    .hiSel   (hiSel),
    .outData (outData)
  );
endmodule

// File: rtl/bitwise_lut_unit_chk.sv
module bitwise_lut_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] opTable,
  input logic              hiSel,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);
  function automatic logic [DATA_W-1:0] refEval(logic [DATA_W-1:0] a,
      logic [DATA_W-1:0] b, logic [DATA_W-1:0] t, logic s);
    logic [3:0] tb;
    logic [DATA_W-1:0] r;
    tb = s ? t[7:4] : t[3:0];
    for (int k = 0; k < DATA_W; k++) begin
      case ({a[k], b[k]})
        2'b00: r[k] = tb[0];
        2'b01: r[k] = tb[1];
        2'b10: r[k] = tb[2];
        default: r[k] = tb[3];
      endcase
    end
    return r;
  endfunction

  logic [DATA_W-1:0] expWord;
  assign expWord = refEval(opA, opB, opTable, hiSel);

  // R1
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && inReady));

  // R4 (also covers R2, R3, R5, R6 data)
  p_result_matches_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outData == $past(expWord)));

  // R6
  p_valid_after_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R7
  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R7
  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8
  p_drain_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |-> inReady);

  // R8
  p_drain_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);
endmodule

bind bitwise_lut_unit bitwise_lut_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_bitwise_lut_unit.sv
`timescale 1ns/100ps
module test_bitwise_lut_unit;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] opA = '0, opB = '0, opTable = '0;
  logic         hiSel = 1'b0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [W-1:0] outData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit stallOn = 1'b0;
  bit thruCheck = 1'b0;
  bit monOn = 1'b0;

  logic [W-1:0] expQ[$];
  string        tagQ[$];

  always #2.5 clk = ~clk;

  bitwise_lut_unit i_bitwise_lut_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .opTable(opTable), .hiSel(hiSel),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // truth table from spec: LSB-0 table bit indexed by {a,b}
  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [W-1:0] t, logic s);
    logic [W-1:0] r;
    int base;
    base = s ? 4 : 0;
    for (int k = 0; k < W; k++) r[k] = t[base + 2*a[k] + b[k]];
    return r;
  endfunction

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // called at a negedge; returns at the negedge after the accepting posedge
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] t, input logic s,
                      input logic [W-1:0] exp, input string tag);
    int waits;
    bit rd;
    waits = 0;
    opA = a; opB = b; opTable = t; hiSel = s; inValid = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    forever begin
      #0.8 rd = inReady;
      @(negedge clk);
      if (rd) break;
      waits++;
    end
    #0.4;
    check(outValid === 1'b1, "R6 valid after accept", W'(outValid), W'(1));
    if (thruCheck)
      check(waits == 0, "R8 back-to-back accept", W'(waits), W'(0));
  endtask

  task automatic idleTo(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: drives outReady, pops and compares at each handshake
  initial begin
    logic         prevStall;
    logic [W-1:0] prevData;
    logic [W-1:0] e;
    string        tg;
    prevStall = 1'b0;
    prevData  = '0;
    forever begin
      @(negedge clk);
      outReady = stallOn ? ($urandom_range(0, 2) != 0) : 1'b1;
      #0.4;
      if (monOn) begin
        if (prevStall) begin
          check(outValid === 1'b1 && outData === prevData, "R7 held during stall",
                outData, prevData);
        end
        if (outValid && !outReady)
          check(inReady === 1'b0, "R7 inReady low in stall", W'(inReady), W'(0));
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R6 unexpected result", outData, '0);
          end else begin
            e  = expQ.pop_front();
            tg = tagQ.pop_front();
            check(outData === e, tg, outData, e);
          end
        end
        prevStall = outValid && !outReady;
        prevData  = outData;
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check(1'b0, "watchdog", W'(cycles), W'(100000));
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] a, b, t;
    repeat (3) @(negedge clk);
    #0.4;
    check(outValid === 1'b0 && inReady === 1'b1, "R1 reset state",
          W'({outValid, inReady}), W'(2'b01));
    rstN = 1'b1;
    @(negedge clk);
    #0.4;
    check(outValid === 1'b0 && inReady === 1'b1, "R1 idle after reset",
          W'({outValid, inReady}), W'(2'b01));
    monOn = 1'b1;

    // R9: AND and XOR, MSB-0 bit 0 is [63]
    for (int n = 0; n < 8; n++) begin
      a = rnd64(); b = rnd64();
      send(a, b, W'(4'b1000), 1'b0, a & b, "R9 AND table");
      send(a, b, W'(8'h60), 1'b1, a ^ b, "R9 XOR table hi nibble");
    end
    // exact bit placement incl. MSB-0 bit 0
    send(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, W'(4'b1000), 1'b0,
         64'h8000_0000_0000_0000, "R4 MSB-0 bit 0 position");
    // R2: table low nibble, junk in upper nibble
    for (int n = 0; n < 8; n++) begin
      a = rnd64(); b = rnd64(); t = rnd64();
      send(a, b, t, 1'b0, model(a, b, t, 1'b0), "R2 low nibble table");
    end
    // R3: high nibble
    for (int n = 0; n < 8; n++) begin
      a = rnd64(); b = rnd64(); t = rnd64();
      send(a, b, t, 1'b1, model(a, b, t, 1'b1), "R3 high nibble table");
    end
    // R4: all 16 functions on all four index patterns
    for (int f = 0; f < 16; f++) begin
      a = 64'hFFFF_FFFF_0000_0000; b = 64'hFFFF_0000_FFFF_0000;
      send(a, b, W'(f), 1'b0,
           {{16{f[3]}}, {16{f[2]}}, {16{f[1]}}, {16{f[0]}}}, "R4 function sweep");
    end
    // R5: unselected bits toggled give same result
    for (int n = 0; n < 6; n++) begin
      a = rnd64(); b = rnd64(); t = rnd64();
      send(a, b, t, 1'b0, model(a, b, t, 1'b0), "R5 base lo");
      send(a, b, t ^ 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, model(a, b, t, 1'b0),
           "R5 unselected bits ignored lo");
      send(a, b, t ^ 64'hFFFF_FFFF_FFFF_FF0F, 1'b1, model(a, b, t, 1'b1),
           "R5 unselected bits ignored hi");
    end
    idleTo(3);
    // R8: back-to-back stream with consumer always ready
    thruCheck = 1'b1;
    for (int n = 0; n < 10; n++) begin
      a = rnd64(); b = rnd64(); t = rnd64();
      send(a, b, t, n[0], model(a, b, t, n[0]), "R8 stream result");
    end
    thruCheck = 1'b0;
    idleTo(2);
    #0.4;
    check(outValid === 1'b0, "R8 valid drops when drained", W'(outValid), W'(0));
    @(negedge clk);
    // R7: random consumer stalls
    stallOn = 1'b1;
    for (int n = 0; n < 60; n++) begin
      a = rnd64(); b = rnd64(); t = rnd64();
      send(a, b, t, n[1], model(a, b, t, n[1]), "R7 result under stall");
      if ($urandom_range(0, 3) == 0) idleTo(1);
    end
    stallOn = 1'b0;
    idleTo(6);
    check(expQ.size() == 0, "R6 all results delivered", W'(expQ.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule